// File: doc/BRIEF.md
# ADV-Strobed Address-Latch Read Sequencer

This block runs single read transfers on an external parallel bus for devices that capture their address on a one-cycle address-valid strobe, in the manner of NOR-style flash. A requester presents a 9-bit address and a chip-select index. The sequencer then drives the active-low chip select, address-valid, output-enable and address lines, samples the 16-bit data bus, and returns the word with a one-cycle done pulse.

Each chip select has its own timing settings. An address-hold enable keeps the address on the bus after the strobe. A 2-bit strobe-to-enable spacing and a 4-bit first-segment length together decide when output enable may assert, and the later of the two wins. The settings are captured when a request is accepted, so they may change freely while a read is in flight.

Top module: `advrd_seq`

## Requirements
- R1: After reset every `cs_n` bit, `adv_n` and `oe_n` are high, `done` is low, `addr_out` is zero and `req_ready` is high.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` high, `req_sel` below NUM_CS) pulls the selected `cs_n` bit and `adv_n` low in the following cycle. `adv_n` stays low for exactly that one cycle.
- R3: Counting the first chip-select cycle as offset 0, `oe_n` first goes low at offset max(H, S). H is the read-hold field `cfg_rd_hold[4*i+3:4*i]` and S is the strobe-spacing field `cfg_adv_oe[2*i+1:2*i]` of chip select i.
- R4: `oe_n` stays low for exactly two cycles. The chip select and `oe_n` are then released together in the next cycle.
- R5: Data on `data_in` is sampled at the clock edge that ends the second output-enable cycle. It appears on `done_data` with `done` high for one cycle, in the first cycle after the chip select is released.
- R6: When `cfg_addr_hold[i]` is 1, `addr_out` carries the request address in every cycle from chip-select assertion through the last output-enable cycle.
- R7: When `cfg_addr_hold[i]` is 0, `addr_out` carries the address only in the strobe cycle and is zero in the rest of the transfer.
- R8: Only the `cs_n` bit for the selected chip select goes low. No more than one `cs_n` bit is ever low.
- R9: `req_ready` is low while a transfer is in progress, and requests presented then are ignored. At least one cycle with all chip selects high separates two transfers. A request accepted in the done cycle starts the next transfer immediately after that cycle.
- R10: Configuration inputs are captured at acceptance. Changing them during a transfer does not alter that transfer's timing or address behaviour.
- R11: `addr_out` is zero whenever no chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_sel | input | 3 | Chip-select index of the request |
| req_addr | input | 9 | Read address |
| req_ready | output | 1 | High when a request can be accepted |
| cfg_addr_hold | input | 6 | Per chip select: keep the address on the bus for the whole transfer |
| cfg_adv_oe | input | 12 | Per chip select: 2-bit strobe-to-enable spacing |
| cfg_rd_hold | input | 24 | Per chip select: 4-bit first-segment length |
| cs_n | output | 6 | Active-low chip selects |
| adv_n | output | 1 | Active-low address-valid strobe |
| oe_n | output | 1 | Active-low output enable |
| addr_out | output | 9 | External address lines |
| data_in | input | 16 | External data bus |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 16 | Captured read data |

## Verification
The assertions assume that `req_sel` stays below the number of chip selects whenever `req_valid` is high, and that `data_in` is settled before the sampling edge. The bench draws indices only from the legal range. It changes `data_in` only at falling edges, putting the expected word on the bus in the second output-enable cycle and a different word in every other cycle. It also scrambles all configuration inputs right after each acceptance, so the timing checks depend only on the values captured at acceptance.

// File: rtl/advrd_pkg.sv
package advrd_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 16;
  localparam int RH_W   = 4;
  localparam int AOE_W  = 2;

  // Offset of the first output-enable cycle from chip-select assertion:
  // the later of the two timing constraints.
  function automatic logic [RH_W-1:0] oe_offset(input logic [RH_W-1:0] rd_hold,
                                                 input logic [AOE_W-1:0] adv_oe);
    logic [RH_W-1:0] aoe_ext;
    aoe_ext = {{(RH_W-AOE_W){1'b0}}, adv_oe};
    return (rd_hold > aoe_ext) ? rd_hold : aoe_ext;
  endfunction
endpackage

// File: rtl/advrd_cfg_sel.sv
module advrd_cfg_sel #(
  parameter int NUM_CS = 6,
  parameter int SW     = 3,
  parameter int RH_W   = 4,
  parameter int AOE_W  = 2
) (
  input  logic [SW-1:0]           sel,
  input  logic [NUM_CS-1:0]       hold_vec,
  input  logic [NUM_CS*AOE_W-1:0] aoe_vec,
  input  logic [NUM_CS*RH_W-1:0]  rh_vec,
  output logic                    sel_ok,
  output logic                    hold,
  output logic [RH_W-1:0]         dly
);
  logic [RH_W-1:0]  rh_pick;
  logic [AOE_W-1:0] aoe_pick;

  assign sel_ok = (int'(sel) < NUM_CS);

  always_comb begin
    hold     = 1'b0;
    rh_pick  = '0;
    aoe_pick = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (int'(sel) == i) begin
        hold     = hold_vec[i];
        rh_pick  = rh_vec[i*RH_W +: RH_W];
        aoe_pick = aoe_vec[i*AOE_W +: AOE_W];
      end
    end
  end

  assign dly = advrd_pkg::oe_offset(rh_pick, aoe_pick);
endmodule

// File: rtl/advrd_core.sv
module advrd_core #(
  parameter int AW   = 9,
  parameter int DW   = 16,
  parameter int DLYW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic            start_hold,
  input  logic [DLYW-1:0] start_dly,
  input  logic [DW-1:0]   data_in,
  output logic            ready,
  output logic            act,
  output logic            adv_act,
  output logic            oe_act,
  output logic [AW-1:0]   addr_out,
  output logic            done,
  output logic [DW-1:0]   done_data
);
  localparam int CW = DLYW + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DONE} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   addr_q;
  logic            hold_q;
  logic [DLYW-1:0] dly_q;
  logic [CW-1:0]   last_cnt;
  logic            last_oe;   // second output-enable cycle: data sample point
  logic            accept;

  assign ready    = (state != S_ACT);
  assign accept   = ready && start;
  assign act      = (state == S_ACT);
  assign adv_act  = act && (cnt == '0);
  assign oe_act   = act && (cnt >= {1'b0, dly_q});
  assign last_cnt = {1'b0, dly_q} + CW'(1);
  assign last_oe  = act && (cnt == last_cnt);
  assign done     = (state == S_DONE);
  assign addr_out = (act && (adv_act || hold_q)) ? addr_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      hold_q    <= 1'b0;
      dly_q     <= '0;
      done_data <= '0;
    end else if (act) begin
      cnt <= cnt + CW'(1);
      if (last_oe) begin
        done_data <= data_in;
        state     <= S_DONE;
      end
    end else if (accept) begin
      state  <= S_ACT;
      cnt    <= '0;
      addr_q <= start_addr;
      hold_q <= start_hold;
      dly_q  <= start_dly;
    end else begin
      state <= S_IDLE;
    end
  end

  // R2: strobe lasts one cycle
  p_adv_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_act |=> !adv_act);
  // R4: output enable held two cycles, then released with the chip select
  p_oe_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_act) |=> oe_act);
  p_oe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_act && $past(oe_act)) |=> !act);
  // R5: done follows the last output-enable cycle, one cycle wide
  p_done_after_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!act && $past(oe_act)));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: every transfer end passes through a done (idle) cycle
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> done);
  // R11: address lines quiet outside a transfer
  p_addr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (addr_out == '0));
endmodule

// File: rtl/advrd_seq.sv
module advrd_seq #(
  parameter int NUM_CS = 6,
  parameter int SW     = 3,
  parameter int AW     = advrd_pkg::ADDR_W,
  parameter int DW     = advrd_pkg::DATA_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [SW-1:0]                         req_sel,
  input  logic [AW-1:0]                         req_addr,
  output logic                                  req_ready,
  input  logic [NUM_CS-1:0]                     cfg_addr_hold,
  input  logic [NUM_CS*advrd_pkg::AOE_W-1:0]    cfg_adv_oe,
  input  logic [NUM_CS*advrd_pkg::RH_W-1:0]     cfg_rd_hold,
  output logic [NUM_CS-1:0]                     cs_n,
  output logic                                  adv_n,
  output logic                                  oe_n,
  output logic [AW-1:0]                         addr_out,
  input  logic [DW-1:0]                         data_in,
  output logic                                  done,
  output logic [DW-1:0]                         done_data
);
  localparam int RH_W  = advrd_pkg::RH_W;
  localparam int AOE_W = advrd_pkg::AOE_W;

  logic            sel_ok, sel_hold, start, act, adv_act, oe_act;
  logic [RH_W-1:0] sel_dly;
  logic [SW-1:0]   sel_q;

  advrd_cfg_sel #(.NUM_CS(NUM_CS), .SW(SW), .RH_W(RH_W), .AOE_W(AOE_W)) cfg_i (
    .sel(req_sel), .hold_vec(cfg_addr_hold), .aoe_vec(cfg_adv_oe), .rh_vec(cfg_rd_hold),
    .sel_ok(sel_ok), .hold(sel_hold), .dly(sel_dly)
  );

  assign start = req_valid && sel_ok;

  advrd_core #(.AW(AW), .DW(DW), .DLYW(RH_W)) core_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(req_addr),
    .start_hold(sel_hold), .start_dly(sel_dly), .data_in(data_in),
    .ready(req_ready), .act(act), .adv_act(adv_act), .oe_act(oe_act),
    .addr_out(addr_out), .done(done), .done_data(done_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sel_q <= '0;
    else if (start && req_ready)     sel_q <= req_sel;
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(act && (int'(sel_q) == g));
  end

  assign adv_n = !adv_act;
  assign oe_n  = !oe_act;

  // R8: at most one chip select active
  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R2: strobe only inside a chip-select window
  p_adv_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_n |-> !(&cs_n));
  // R4: output enable only inside a chip-select window
  p_oe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !(&cs_n));
endmodule

// File: tb/advrd_seq_tb_top.sv
module advrd_seq_tb_top;
  localparam int NCS = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic [2:0]     req_sel = '0;
  logic [8:0]     req_addr = '0;
  logic           req_ready;
  logic [NCS-1:0] cfg_addr_hold = '0;
  logic [2*NCS-1:0] cfg_adv_oe = '0;
  logic [4*NCS-1:0] cfg_rd_hold = '0;
  logic [NCS-1:0] cs_n;
  logic           adv_n, oe_n, done;
  logic [8:0]     addr_out;
  logic [15:0]    data_in = '0;
  logic [15:0]    done_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  advrd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_addr(req_addr), .req_ready(req_ready), .cfg_addr_hold(cfg_addr_hold),
    .cfg_adv_oe(cfg_adv_oe), .cfg_rd_hold(cfg_rd_hold), .cs_n(cs_n),
    .adv_n(adv_n), .oe_n(oe_n), .addr_out(addr_out), .data_in(data_in),
    .done(done), .done_data(done_data)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act_v, exp_v, $time);
    end
  endtask

  function automatic int exp_dly(input int rh, input int ao);
    return (ao > rh) ? ao : rh;
  endfunction

  function automatic logic [NCS-1:0] exp_cs(input int sel);
    logic [NCS-1:0] e;
    e = '1;
    e[sel] = 1'b0;
    return e;
  endfunction

  task automatic scramble_cfg();
    cfg_addr_hold = NCS'($urandom);
    cfg_adv_oe    = (2*NCS)'($urandom);
    cfg_rd_hold   = (4*NCS)'($urandom);
  endtask

  // Entered and left at a falling edge. Leaves in the done cycle.
  task automatic run_read(input int sel, input int addr, input bit hold,
                          input int rh, input int ao, input bit busy_req);
    int d;
    logic [15:0] dat;
    scramble_cfg();
    cfg_addr_hold[sel]        = hold;
    cfg_adv_oe[2*sel +: 2]    = 2'(ao);
    cfg_rd_hold[4*sel +: 4]   = 4'(rh);
    chk(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_sel   = 3'(sel);
    req_addr  = 9'(addr);
    @(posedge clk);
    @(negedge clk);
    req_valid = busy_req;
    req_sel   = 3'($urandom_range(0, NCS-1));
    req_addr  = 9'($urandom);
    scramble_cfg();                        // R10: must not affect this transfer
    d   = exp_dly(rh, ao);
    dat = 16'($urandom);
    for (int k = 0; k <= d + 1; k++) begin
      data_in = (k == d + 1) ? dat : ~dat ^ 16'(k);
      chk(cs_n == exp_cs(sel), "R8 cs select", int'(cs_n), int'(exp_cs(sel)));
      chk(adv_n == (k != 0), "R2 adv strobe", int'(adv_n), int'(k != 0));
      chk(oe_n == (k < d), "R3 R10 oe timing", int'(oe_n), int'(k < d));
      if (k == 0 || hold)
        chk(addr_out == 9'(addr), "R6 address driven", int'(addr_out), addr);
      else
        chk(addr_out == 9'd0, "R7 address zeroed", int'(addr_out), 0);
      chk(req_ready == 1'b0 && done == 1'b0, "R9 busy", int'({req_ready, done}), 0);
      if (k == d + 1) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(cs_n == '1 && oe_n && adv_n, "R4 release", int'({cs_n, oe_n, adv_n}), 'hff);
    chk(done == 1'b1, "R5 done pulse", int'(done), 1);
    chk(done_data == dat, "R5 data", int'(done_data), int'(dat));
    chk(addr_out == 9'd0, "R11 addr idle", int'(addr_out), 0);
    chk(req_ready == 1'b1, "R9 ready in done", int'(req_ready), 1);
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(cs_n == '1 && done == 1'b0, "R9 R5 idle after done", int'({cs_n, done}), 'h3f << 1);
    chk(addr_out == 9'd0, "R11 addr idle", int'(addr_out), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    #3;
    chk(cs_n == '1 && adv_n && oe_n, "R1 strobes in reset", int'({cs_n, adv_n, oe_n}), 'hff);
    chk(done == 0 && addr_out == 0 && req_ready == 1, "R1 outputs in reset",
        int'({done, addr_out, req_ready}), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == '1 && done == 0, "R1 after reset", int'({cs_n, done}), 'h3f << 1);

    // Directed corners
    run_read(0, 9'h1ff, 1, 0, 0, 0);  idle_check();        // OE with CS, hold on
    run_read(1, 9'h0a5, 0, 0, 0, 0);  idle_check();        // OE with CS, hold off
    run_read(2, 9'h155, 1, 15, 0, 0); idle_check();        // long first segment
    run_read(3, 9'h0f0, 0, 0, 3, 0);  idle_check();        // spacing dominates
    run_read(4, 9'h033, 1, 2, 3, 1);  idle_check();        // request while busy ignored
    run_read(5, 9'h100, 0, 3, 2, 0);                       // back-to-back next
    run_read(0, 9'h001, 0, 1, 1, 0);  idle_check();

    // Constrained random
    for (int n = 0; n < 150; n++) begin
      run_read($urandom_range(0, NCS-1), $urandom_range(0, 511), 1'($urandom),
               $urandom_range(0, 15), $urandom_range(0, 3), ($urandom_range(0, 4) == 0));
      if ($urandom_range(0, 2) == 0) idle_check();
      else if ($urandom_range(0, 1) == 0) begin
        @(negedge clk);
        for (int w = 0; w < int'($urandom_range(0, 3)); w++) @(negedge clk);
      end
    end
    idle_check();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule